// File: doc/BRIEF.md
# Strapped Multi-Chip Indirect Register Bridge

This block is the device-side access logic of a management-bus slave that contains up to 32 internal register devices, each with 32 sixteen-bit registers. An upstream decoder presents each bus transaction already parsed: a 5-bit bus address, a 5-bit register number, a direction and write data. The bridge decides whether the transaction is addressed to this chip. It then either forwards it to the internal register-file port or handles it in its own two-register window.

A 4-bit strap supplies bits 4:1 of the chip's bus address, and bit 0 is always zero. With an all-zero strap, the chip assumes it is alone on the bus. Every bus address then maps straight onto the internal device of the same number, in the same cycle. With any other strap value, the chip responds only at its own even address, and only through a command register and a data register. Software places a write value in the data register if one is needed. It then writes a command word with the busy flag set. The bridge performs the internal access over `ACCESS_CYCLES` clock cycles and then clears busy. For a read, the result is in the data register by the time busy clears.

Top module: `strap_reg_bridge`

## Requirements
- R1: The chip address is {strap, 1'b0}. With a non-zero strap, `txn_hit` is high only for a valid transaction whose bus address equals the chip address and whose register number is 0 (command) or 1 (data).
- R2: With a zero strap, every valid transaction raises `txn_hit` and drives the internal port in the same cycle: `int_req` high, `int_dev` = bus address, `int_reg` = register number, `int_write` and `int_wdata` copied, and a read returns `int_rdata` on `txn_rdata`.
- R3: Command word layout: bit 15 busy, bit 12 set for the supported frame style, bits 11:10 opcode (2'b10 read, 2'b01 write), bits 9:5 internal device, bits 4:0 internal register, bits 14:13 stored only. A command write with bit 15 clear stores the word and starts nothing.
- R4: A command write with bit 15 set keeps busy high for exactly `ACCESS_CYCLES` cycles. A read of register 0 returns {busy, stored bits 14:0}.
- R5: A write command issues exactly one internal write strobe, in the last busy cycle, carrying the data register value to the addressed device and register.
- R6: A read command loads the addressed internal register into the data register on the edge that clears busy.
- R7: When bit 12 is clear, or the opcode is neither 2'b10 nor 2'b01, busy clears after the same `ACCESS_CYCLES` with no internal strobe and the data register unchanged.
- R8: While busy is set, writes to the command or data register are ignored.
- R9: With a non-zero strap, a transaction that does not hit returns 0 on `txn_rdata`, causes no internal strobe and changes no state.
- R10: After reset, busy is clear and both the command and data registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 4 | Chip address bits 4:1 |
| txn_valid | input | 1 | Decoded transaction present this cycle |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_phy | input | 5 | Bus address of the transaction |
| txn_reg | input | 5 | Register number of the transaction |
| txn_wdata | input | 16 | Write data |
| txn_hit | output | 1 | Transaction is claimed by this chip |
| txn_rdata | output | 16 | Read data, same cycle |
| int_req | output | 1 | Internal access strobe |
| int_write | output | 1 | Internal access is a write |
| int_dev | output | 5 | Internal device number |
| int_reg | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data, combinational from int_dev/int_reg |

## Verification
A stuck or miscounted busy counter appears on the very next read of the command register as a busy flag held the wrong number of polls, and the bench counts those polls exactly. A wrong latched target or data register shows up when the bench's device model receives a strobe at the wrong location, or when the data read back after busy clears differs from the bench's shadow copy. Each such error is detected within one command. Leakage through the window, such as a strobe for an invalid opcode, a write accepted while busy, or a claim of an unowned address, is caught by a strobe count that is compared after every command.

// File: rtl/strap_bridge_pkg.sv
package strap_bridge_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int STRAP_W = ADDR_W - 1;

   localparam int BUSY_BIT = 15;
   localparam int STYLE_BIT = 12;

   typedef enum logic [1:0] {
      OPC_NONE  = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_BOTH  = 2'b11
   } opc_t;

   typedef struct packed {
      logic [1:0]        spare;
      logic              style;
      opc_t              opc;
      logic [ADDR_W-1:0] dev;
      logic [ADDR_W-1:0] rsel;
   } cmd_t;

   function automatic logic cmd_runnable(cmd_t c);
      return c.style && (c.opc == OPC_READ || c.opc == OPC_WRITE);
   endfunction
endpackage

// File: rtl/srb_addr_decode.sv
module srb_addr_decode
   import strap_bridge_pkg::*;
(
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               txn_valid,
   input  logic [ADDR_W-1:0]  txn_phy,
   input  logic [ADDR_W-1:0]  txn_reg,
   output logic               direct_mode,
   output logic               win_hit,
   output logic               sel_cmd,
   output logic               sel_data
);
   localparam logic [ADDR_W-1:0] REG_CMD  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] REG_DATA = ADDR_W'(1);

   logic [ADDR_W-1:0] own_addr;
   logic              addr_match;

   assign own_addr    = {strap_addr, 1'b0};
   assign direct_mode = (strap_addr == '0);
   assign addr_match  = txn_valid && !direct_mode && (txn_phy == own_addr);
   assign sel_cmd     = addr_match && (txn_reg == REG_CMD);
   assign sel_data    = addr_match && (txn_reg == REG_DATA);
   assign win_hit     = sel_cmd || sel_data;
endmodule

// File: rtl/srb_cmd_engine.sv
module srb_cmd_engine
   import strap_bridge_pkg::*;
#(
   parameter int ACCESS_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cmd,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] int_rdata,
   output logic              busy,
   output logic [DATA_W-1:0] cmd_word,
   output logic [DATA_W-1:0] data_word,
   output logic              eng_req,
   output logic              eng_write,
   output logic [ADDR_W-1:0] eng_dev,
   output logic [ADDR_W-1:0] eng_reg
);
   cmd_t              cmd_q;
   logic [DATA_W-1:0] data_q;
   logic              busy_q;
   logic              launch;
   logic              at_last;

   assign launch = wr_cmd && !busy_q && wdata[BUSY_BIT];

   generate
      if (ACCESS_CYCLES < 1) begin : g_bad_cfg
         $error("srb_cmd_engine: ACCESS_CYCLES must be at least 1");
      end
      if (ACCESS_CYCLES == 1) begin : g_single
         assign at_last = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(ACCESS_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(ACCESS_CYCLES - 1);
         logic [CW-1:0] remain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain_q <= '0;
            end else if (launch) begin
               remain_q <= LAST;
            end else if (busy_q && remain_q != '0) begin
               remain_q <= remain_q - 1'b1;
            end
         end
         assign at_last = (remain_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cmd_q  <= '0;
         data_q <= '0;
      end else if (!busy_q) begin
         if (wr_cmd) begin
            cmd_q  <= cmd_t'(wdata[DATA_W-2:0]);
            busy_q <= wdata[BUSY_BIT];
         end
         if (wr_data) begin
            data_q <= wdata;
         end
      end else if (at_last) begin
         busy_q <= 1'b0;
         if (cmd_runnable(cmd_q) && cmd_q.opc == OPC_READ) begin
            data_q <= int_rdata;
         end
      end
   end

   assign busy      = busy_q;
   assign cmd_word  = {busy_q, cmd_q};
   assign data_word = data_q;
   assign eng_req   = busy_q && at_last && cmd_runnable(cmd_q);
   assign eng_write = (cmd_q.opc == OPC_WRITE);
   assign eng_dev   = cmd_q.dev;
   assign eng_reg   = cmd_q.rsel;
endmodule

// File: rtl/strap_reg_bridge.sv
module strap_reg_bridge
   import strap_bridge_pkg::*;
#(
   parameter int ACCESS_CYCLES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               txn_valid,
   input  logic               txn_write,
   input  logic [ADDR_W-1:0]  txn_phy,
   input  logic [ADDR_W-1:0]  txn_reg,
   input  logic [DATA_W-1:0]  txn_wdata,
   output logic               txn_hit,
   output logic [DATA_W-1:0]  txn_rdata,
   output logic               int_req,
   output logic               int_write,
   output logic [ADDR_W-1:0]  int_dev,
   output logic [ADDR_W-1:0]  int_reg,
   output logic [DATA_W-1:0]  int_wdata,
   input  logic [DATA_W-1:0]  int_rdata
);
   logic              direct_mode;
   logic              win_hit;
   logic              sel_cmd;
   logic              sel_data;
   logic              eng_busy;
   logic [DATA_W-1:0] eng_cmd;
   logic [DATA_W-1:0] eng_data;
   logic              eng_req;
   logic              eng_write;
   logic [ADDR_W-1:0] eng_dev;
   logic [ADDR_W-1:0] eng_reg;

   srb_addr_decode u_decode (
      .strap_addr (strap_addr),
      .txn_valid  (txn_valid),
      .txn_phy    (txn_phy),
      .txn_reg    (txn_reg),
      .direct_mode(direct_mode),
      .win_hit    (win_hit),
      .sel_cmd    (sel_cmd),
      .sel_data   (sel_data)
   );

   srb_cmd_engine #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (sel_cmd && txn_write),
      .wr_data  (sel_data && txn_write),
      .wdata    (txn_wdata),
      .int_rdata(int_rdata),
      .busy     (eng_busy),
      .cmd_word (eng_cmd),
      .data_word(eng_data),
      .eng_req  (eng_req),
      .eng_write(eng_write),
      .eng_dev  (eng_dev),
      .eng_reg  (eng_reg)
   );

   always_comb begin
      if (direct_mode) begin
         txn_hit   = txn_valid;
         txn_rdata = int_rdata;
         int_req   = txn_valid;
         int_write = txn_write;
         int_dev   = txn_phy;
         int_reg   = txn_reg;
         int_wdata = txn_wdata;
      end else begin
         txn_hit   = win_hit;
         txn_rdata = sel_cmd ? eng_cmd : (sel_data ? eng_data : '0);
         int_req   = eng_req;
         int_write = eng_write;
         int_dev   = eng_dev;
         int_reg   = eng_reg;
         int_wdata = eng_data;
      end
   end
endmodule

// File: rtl/strap_reg_bridge_chk.sv
module strap_reg_bridge_chk
   import strap_bridge_pkg::*;
#(
   parameter int ACCESS_CYCLES = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [STRAP_W-1:0] strap_addr,
   input logic               txn_valid,
   input logic [ADDR_W-1:0]  txn_phy,
   input logic [ADDR_W-1:0]  txn_reg,
   input logic               txn_hit,
   input logic               int_req,
   input logic               int_write,
   input logic               busy,
   input logic [DATA_W-1:0]  data_word
);
   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else        busy_run <= busy ? busy_run + 1 : 0;
   end

   // R1
   a_r1_hit_only_window: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_addr != '0 && txn_hit) |->
         (txn_valid && txn_phy == {strap_addr, 1'b0} && txn_reg < ADDR_W'(2)));

   // R2
   a_r2_direct_claims_all: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_addr == '0 && txn_valid) |-> (txn_hit && int_req));

   // R4
   a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < ACCESS_CYCLES));

   // R4
   a_r4_busy_full_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == ACCESS_CYCLES));

   // R5
   a_r5_strobe_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_addr != '0 && int_req) |=> !busy);

   // R9
   a_r9_no_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_addr != '0 && !busy) |-> !int_req);

   // R8
   a_r8_data_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(int_req && !int_write)) |=> $stable(data_word));
endmodule

bind strap_reg_bridge strap_reg_bridge_chk #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strap_addr(strap_addr),
   .txn_valid (txn_valid),
   .txn_phy   (txn_phy),
   .txn_reg   (txn_reg),
   .txn_hit   (txn_hit),
   .int_req   (int_req),
   .int_write (int_write),
   .busy      (eng_busy),
   .data_word (eng_data)
);

// File: tb/strap_reg_bridge_bench.sv
module strap_reg_bridge_bench;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  strap_addr = 4'h3;
   logic        txn_valid = 1'b0;
   logic        txn_write = 1'b0;
   logic [4:0]  txn_phy = '0;
   logic [4:0]  txn_reg = '0;
   logic [15:0] txn_wdata = '0;
   logic        txn_hit;
   logic [15:0] txn_rdata;
   logic        int_req;
   logic        int_write;
   logic [4:0]  int_dev;
   logic [4:0]  int_reg;
   logic [15:0] int_wdata;
   logic [15:0] int_rdata;

   logic [15:0] mem    [32][32];
   logic [15:0] shadow [32][32];
   int strobes = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   strap_reg_bridge #(.ACCESS_CYCLES(LAT)) u_strap_reg_bridge (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
      .txn_valid(txn_valid), .txn_write(txn_write), .txn_phy(txn_phy),
      .txn_reg(txn_reg), .txn_wdata(txn_wdata), .txn_hit(txn_hit),
      .txn_rdata(txn_rdata), .int_req(int_req), .int_write(int_write),
      .int_dev(int_dev), .int_reg(int_reg), .int_wdata(int_wdata),
      .int_rdata(int_rdata)
   );

   // device model
   assign int_rdata = mem[int_dev][int_reg];
   always @(posedge clk) begin
      if (int_req) begin
         strobes <= strobes + 1;
         if (int_write) mem[int_dev][int_reg] <= int_wdata;
      end
   end

   function automatic logic [15:0] seed_val(int d, int r);
      return 16'((d * 16'h0971) ^ (r * 16'h1D03) ^ 16'h5A5A);
   endfunction

   function automatic logic [15:0] mk_cmd(logic go, logic style, logic [1:0] opc,
                                          logic [4:0] d, logic [4:0] r);
      return {go, 2'b00, style, opc, d, r};
   endfunction

   task automatic check(input logic ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic bus(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, output logic [15:0] rd, output logic hit);
      @(negedge clk);
      txn_valid = 1'b1; txn_write = wr; txn_phy = phy; txn_reg = rg; txn_wdata = wd;
      #1;
      rd = txn_rdata; hit = txn_hit;
      @(posedge clk);
      #1 txn_valid = 1'b0;
   endtask

   function automatic logic [4:0] own();
      return {strap_addr, 1'b0};
   endfunction

   task automatic poll(output int busy_seen, output logic [15:0] last_cmd);
      logic [15:0] rd;
      logic h;
      busy_seen = 0;
      for (int i = 0; i < 40; i++) begin
         bus(1'b0, own(), 5'd0, 16'h0, rd, h);
         last_cmd = rd;
         if (!rd[15]) break;
         busy_seen++;
      end
   endtask

   task automatic do_reset(input logic [3:0] s);
      rst_n = 1'b0;
      strap_addr = s;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      report();
   end

   initial begin
      logic [15:0] rd;
      logic h;
      int nb;
      int s0;
      logic [15:0] lc;
      void'($urandom(32'h1234_5678));
      for (int d = 0; d < 32; d++)
         for (int r = 0; r < 32; r++) begin
            mem[d][r] = seed_val(d, r);
            shadow[d][r] = seed_val(d, r);
         end

      do_reset(4'h3);

      // R10 reset state
      bus(1'b0, own(), 5'd0, 16'h0, rd, h);
      check(h && rd == 16'h0, "R10 cmd after reset", rd, 16'h0);
      bus(1'b0, own(), 5'd1, 16'h0, rd, h);
      check(h && rd == 16'h0, "R10 data after reset", rd, 16'h0);

      // R1 / R9 address decode
      bus(1'b0, 5'd7, 5'd0, 16'h0, rd, h);
      check(!h && rd == 16'h0, "R9 odd neighbour address", {15'h0, h}, 16'h0);
      bus(1'b0, own(), 5'd2, 16'h0, rd, h);
      check(!h && rd == 16'h0, "R1 register 2 not claimed", {15'h0, h}, 16'h0);
      bus(1'b0, own(), 5'd1, 16'h0, rd, h);
      check(h, "R1 data register claimed", {15'h0, h}, 16'h1);

      // R3 stored without launch
      s0 = strobes;
      bus(1'b1, own(), 5'd0, mk_cmd(1'b0, 1'b1, 2'b10, 5'd4, 5'd6), rd, h);
      bus(1'b0, own(), 5'd0, 16'h0, rd, h);
      check(rd == mk_cmd(1'b0, 1'b1, 2'b10, 5'd4, 5'd6) && strobes == s0,
            "R3 command stored idle", rd, mk_cmd(1'b0, 1'b1, 2'b10, 5'd4, 5'd6));

      // R4 / R5 indirect write
      s0 = strobes;
      bus(1'b1, own(), 5'd1, 16'hBEEF, rd, h);
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b01, 5'd5, 5'd9), rd, h);
      poll(nb, lc);
      shadow[5][9] = 16'hBEEF;
      check(nb == LAT, "R4 busy length", 16'(nb), 16'(LAT));
      check(mem[5][9] == 16'hBEEF, "R5 target written", mem[5][9], 16'hBEEF);
      check(strobes == s0 + 1, "R5 single strobe", 16'(strobes - s0), 16'h1);

      // R6 indirect read
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b10, 5'd17, 5'd3), rd, h);
      poll(nb, lc);
      bus(1'b0, own(), 5'd1, 16'h0, rd, h);
      check(rd == shadow[17][3], "R6 read result", rd, shadow[17][3]);

      // R8 writes while busy ignored
      bus(1'b1, own(), 5'd1, 16'h1234, rd, h);
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b01, 5'd2, 5'd4), rd, h);
      bus(1'b1, own(), 5'd1, 16'hFFFF, rd, h);
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b10, 5'd8, 5'd8), rd, h);
      poll(nb, lc);
      shadow[2][4] = 16'h1234;
      check(mem[2][4] == 16'h1234, "R8 data write ignored while busy", mem[2][4], 16'h1234);
      check(lc == mk_cmd(1'b0, 1'b1, 2'b01, 5'd2, 5'd4), "R8 command write ignored while busy",
            lc, mk_cmd(1'b0, 1'b1, 2'b01, 5'd2, 5'd4));
      bus(1'b0, own(), 5'd1, 16'h0, rd, h);
      check(rd == 16'h1234, "R8 data register kept", rd, 16'h1234);

      // R7 invalid commands
      s0 = strobes;
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b0, 2'b10, 5'd1, 5'd1), rd, h);
      poll(nb, lc);
      check(nb == LAT && strobes == s0, "R7 style bit clear", 16'(strobes - s0), 16'h0);
      bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b11, 5'd1, 5'd1), rd, h);
      poll(nb, lc);
      check(nb == LAT && strobes == s0, "R7 opcode 11", 16'(strobes - s0), 16'h0);
      bus(1'b0, own(), 5'd1, 16'h0, rd, h);
      check(rd == 16'h1234, "R7 data unchanged", rd, 16'h1234);

      // R9 misses leave state alone
      bus(1'b1, 5'd8, 5'd0, mk_cmd(1'b1, 1'b1, 2'b01, 5'd0, 5'd0), rd, h);
      bus(1'b1, own(), 5'd5, 16'hAAAA, rd, h);
      bus(1'b0, own(), 5'd0, 16'h0, rd, h);
      check(!rd[15] && strobes == s0 && rd == mk_cmd(1'b0, 1'b1, 2'b11, 5'd1, 5'd1),
            "R9 miss has no effect", rd, mk_cmd(1'b0, 1'b1, 2'b11, 5'd1, 5'd1));

      // random indirect traffic
      for (int i = 0; i < 40; i++) begin
         logic [4:0] d, r;
         logic [15:0] v;
         d = 5'($urandom); r = 5'($urandom); v = 16'($urandom);
         bus(1'b1, own(), 5'd1, v, rd, h);
         bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b01, d, r), rd, h);
         poll(nb, lc);
         shadow[d][r] = v;
         d = 5'($urandom); r = 5'($urandom);
         bus(1'b1, own(), 5'd0, mk_cmd(1'b1, 1'b1, 2'b10, d, r), rd, h);
         poll(nb, lc);
         bus(1'b0, own(), 5'd1, 16'h0, rd, h);
         check(rd == shadow[d][r] && nb == LAT, "R6 random indirect read", rd, shadow[d][r]);
      end

      // R2 direct mode
      do_reset(4'h0);
      bus(1'b1, 5'd9, 5'd20, 16'hC0DE, rd, h);
      shadow[9][20] = 16'hC0DE;
      check(h && mem[9][20] == 16'hC0DE, "R2 direct write", mem[9][20], 16'hC0DE);
      bus(1'b0, 5'd31, 5'd1, 16'h0, rd, h);
      check(h && rd == shadow[31][1], "R2 direct read addr 31", rd, shadow[31][1]);
      for (int i = 0; i < 20; i++) begin
         logic [4:0] d, r;
         logic [15:0] v;
         d = 5'($urandom); r = 5'($urandom); v = 16'($urandom);
         bus(1'b1, d, r, v, rd, h);
         shadow[d][r] = v;
         d = 5'($urandom); r = 5'($urandom);
         bus(1'b0, d, r, 16'h0, rd, h);
         check(h && rd == shadow[d][r], "R2 random direct read", rd, shadow[d][r]);
      end

      report();
   end
endmodule